// File: doc/BRIEF.md
# Low-Power DRAM Extended Mode Register Capture

This block sits on the device side of a synchronous DRAM command bus and snoops it for writes to the extended mode register. That register holds two settings. The first is the portion of the array that is kept alive during self-refresh. The second is the output driver strength. When a legal write arrives, the block decodes the address bus into both settings and presents them on its outputs, so the refresh and pad logic can use them.

The block enforces the conditions under which such a write is allowed. Clock enable must be steady high, and every bank must be idle and precharged. Address bits outside the two fields must be zero. A write that breaks one of these rules is refused and raises an error flag. The write also needs a recovery period, and the block signals this with a busy output. Any real command issued while busy is high counts as a timing violation.

All error flags are sticky, and they clear only on reset. Reset also restores the default settings: full-array refresh and half driver strength.

Top module: `lpdram_extreg`

## Requirements
- R1: Synchronous active-high reset sets refresh_area to 3'b000 (full array), drive_strength to 2'b01 (half), busy to 0, and clears all four error flags.
- R2: A register write is cs_n, ras_n, cas_n and we_n all low with ba = 2'b10. When the write is accepted, refresh_area takes addr[2:0] and drive_strength takes addr[6:5] from the cycle after the command. The field codes are: area 000 full, 001 half, 010 quarter; drive 00 full, 01 half, 10 quarter, 11 eighth.
- R3: The same command with ba other than 2'b10 is not a register write. It leaves the settings unchanged and raises no flag.
- R4: An accepted write drives busy high for exactly the one cycle after the command.
- R5: While busy is high, any command other than a NOP sets err_timing. A NOP is cs_n high, or cs_n low with ras_n, cas_n and we_n all high. A register write issued while busy is refused.
- R6: A register write is refused, and err_state is set, unless cke was high at both the command edge and the previous clock edge. The history of cke starts low at reset.
- R7: A register write is refused, and err_state is set, when any bit of bank_idle is low.
- R8: A register write that is otherwise legal, but has a nonzero address bit outside bits 0, 1, 2, 5 and 6, is refused and sets err_rsvd_bits.
- R9: An accepted write with an area code from 3'b011 to 3'b111 stores that code as written and sets err_rsvd_code.
- R10: The register accepts any number of rewrites, including after read, write and activate traffic. Error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | ADDR_W (13) | Address bus |
| bank_idle | input | NUM_BANKS (4) | One bit per bank, high when that bank is idle and precharged |
| refresh_area | output | 3 | Stored self-refresh area code |
| drive_strength | output | 2 | Stored driver strength code |
| busy | output | 1 | High during the recovery cycle after an accepted write |
| err_timing | output | 1 | Sticky: a non-NOP command was issued during recovery |
| err_state | output | 1 | Sticky: a write arrived without stable cke or with a bank not idle |
| err_rsvd_bits | output | 1 | Sticky: a write carried nonzero reserved address bits |
| err_rsvd_code | output | 1 | Sticky: a reserved area code was stored |

## Verification
The hardest case to reach is the cke history. A write must be refused when cke is high at the command edge but was low one edge earlier. Reaching this needs a cke drop followed directly by a write in the next cycle. The bench drives cke as part of each command, so it can lower cke for one NOP and raise it together with the write. The second hard case is back-to-back commands inside the recovery window. The bench issues a second write, a read, and a chip-selected NOP immediately after an accepted write. This separates a refused write that raises a flag from a harmless NOP that must not raise one.

// File: rtl/lpdram_extreg_pkg.sv
package lpdram_extreg_pkg;

    typedef logic [2:0] area_t;

    localparam area_t AREA_FULL    = 3'd0;
    localparam area_t AREA_HALF    = 3'd1;
    localparam area_t AREA_QUARTER = 3'd2;

    typedef enum logic [1:0] {
        DRV_FULL    = 2'd0,
        DRV_HALF    = 2'd1,
        DRV_QUARTER = 2'd2,
        DRV_EIGHTH  = 2'd3
    } drive_e;

    typedef struct packed {
        area_t  area;
        drive_e drive;
    } xreg_t;

    localparam xreg_t XREG_DEFAULT = '{area: AREA_FULL, drive: DRV_HALF};

    typedef struct packed {
        logic nop;
        logic xwrite;
    } cmd_t;

    typedef struct packed {
        logic timing;
        logic state;
        logic rsvd_bits;
        logic rsvd_code;
    } err_t;

    localparam logic [1:0] XREG_BANK_SEL = 2'b10;

    function automatic logic area_reserved(area_t a);
        return a > AREA_QUARTER;
    endfunction

endpackage

// File: rtl/lpdram_extreg_decode.sv
module lpdram_extreg_decode
    import lpdram_extreg_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd,
    output xreg_t             fields,
    output logic              rsvd_hit
);
    localparam logic [ADDR_W-1:0] USED_MASK = ADDR_W'(7'b110_0111);

    logic strobes_low;

    always_comb begin
        strobes_low  = !ras_n && !cas_n && !we_n;
        cmd.nop      = cs_n || (ras_n && cas_n && we_n);
        cmd.xwrite   = !cs_n && strobes_low && (ba == XREG_BANK_SEL);
        fields.area  = addr[2:0];
        fields.drive = drive_e'(addr[6:5]);
        rsvd_hit     = |(addr & ~USED_MASK);
    end
endmodule

// File: rtl/lpdram_extreg_recov.sv
module lpdram_extreg_recov #(
    parameter int RECOV_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = (RECOV_CYCLES > 2) ? $clog2(RECOV_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(RECOV_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/lpdram_extreg_core.sv
module lpdram_extreg_core
    import lpdram_extreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cke,
    input  logic  all_idle,
    input  logic  busy,
    input  cmd_t  cmd,
    input  xreg_t fields,
    input  logic  rsvd_hit,
    output logic  accept,
    output xreg_t xreg,
    output err_t  err
);
    logic  cke_q;
    xreg_t xreg_n;
    err_t  err_n;

    always_comb begin
        xreg_n = xreg;
        err_n  = err;
        accept = 1'b0;
        if (cmd.xwrite && !busy) begin
            if (!(cke && cke_q) || !all_idle) begin
                err_n.state = 1'b1;
            end else if (rsvd_hit) begin
                err_n.rsvd_bits = 1'b1;
            end else begin
                accept = 1'b1;
                xreg_n = fields;
                if (area_reserved(fields.area)) begin
                    err_n.rsvd_code = 1'b1;
                end
            end
        end
        if (busy && !cmd.nop) begin
            err_n.timing = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q <= 1'b0;
            xreg  <= XREG_DEFAULT;
            err   <= '0;
        end else begin
            cke_q <= cke;
            xreg  <= xreg_n;
            err   <= err_n;
        end
    end
endmodule

// File: rtl/lpdram_extreg.sv
module lpdram_extreg
    import lpdram_extreg_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int NUM_BANKS    = 4,
    parameter int RECOV_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [1:0]           ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BANKS-1:0] bank_idle,
    output logic [2:0]           refresh_area,
    output logic [1:0]           drive_strength,
    output logic                 busy,
    output logic                 err_timing,
    output logic                 err_state,
    output logic                 err_rsvd_bits,
    output logic                 err_rsvd_code
);
    cmd_t  cmd;
    xreg_t fields;
    xreg_t xreg;
    err_t  err;
    logic  rsvd_hit;
    logic  accept;

    lpdram_extreg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr     (addr),
        .cmd      (cmd),
        .fields   (fields),
        .rsvd_hit (rsvd_hit)
    );

    lpdram_extreg_core u_core (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .all_idle (&bank_idle),
        .busy     (busy),
        .cmd      (cmd),
        .fields   (fields),
        .rsvd_hit (rsvd_hit),
        .accept   (accept),
        .xreg     (xreg),
        .err      (err)
    );

    lpdram_extreg_recov #(.RECOV_CYCLES(RECOV_CYCLES)) u_recov (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (busy)
    );

    assign refresh_area   = xreg.area;
    assign drive_strength = xreg.drive;
    assign err_timing     = err.timing;
    assign err_state      = err.state;
    assign err_rsvd_bits  = err.rsvd_bits;
    assign err_rsvd_code  = err.rsvd_code;
endmodule

// File: rtl/lpdram_extreg_chk.sv
module lpdram_extreg_chk #(
    parameter int ADDR_W    = 13,
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [1:0]           ba,
    input logic [ADDR_W-1:0]    addr,
    input logic [NUM_BANKS-1:0] bank_idle,
    input logic [2:0]           refresh_area,
    input logic [1:0]           drive_strength,
    input logic                 busy,
    input logic                 err_timing,
    input logic                 err_state,
    input logic                 err_rsvd_bits,
    input logic                 err_rsvd_code
);
    logic       past_valid = 1'b0;
    logic       lmr_cmd;
    logic       xw_cmd;
    logic       real_cmd;
    logic [3:0] err_vec;

    always_ff @(posedge clk) begin
        if (rst) past_valid <= 1'b1;
    end

    assign lmr_cmd  = !cs_n && !ras_n && !cas_n && !we_n;
    assign xw_cmd   = lmr_cmd && (ba == 2'b10);
    assign real_cmd = !cs_n && !(ras_n && cas_n && we_n);
    assign err_vec  = {err_timing, err_state, err_rsvd_bits, err_rsvd_code};

    // R2
    settings_source_chk: assert property (@(posedge clk) disable iff (rst)
        (past_valid && !$past(rst) &&
         (refresh_area != $past(refresh_area) || drive_strength != $past(drive_strength)))
        |-> $past(xw_cmd));

    // R3
    other_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (lmr_cmd && ba != 2'b10) |=> ($stable(refresh_area) && $stable(drive_strength)));

    // R4
    busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $rose(busy)) |-> $past(xw_cmd));

    // R5
    timing_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && real_cmd) |=> err_timing);

    // R7
    idle_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (xw_cmd && !busy && !(&bank_idle)) |=> err_state);

    // R9
    rsvd_code_chk: assert property (@(posedge clk) disable iff (rst)
        (refresh_area > 3'd2) |-> err_rsvd_code);

    // R10
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        (past_valid && !$past(rst)) |-> ((err_vec & $past(err_vec)) == $past(err_vec)));
endmodule

bind lpdram_extreg lpdram_extreg_chk #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cs_n           (cs_n),
    .ras_n          (ras_n),
    .cas_n          (cas_n),
    .we_n           (we_n),
    .ba             (ba),
    .addr           (addr),
    .bank_idle      (bank_idle),
    .refresh_area   (refresh_area),
    .drive_strength (drive_strength),
    .busy           (busy),
    .err_timing     (err_timing),
    .err_state      (err_state),
    .err_rsvd_bits  (err_rsvd_bits),
    .err_rsvd_code  (err_rsvd_code)
);

// File: tb/lpdram_extreg_bench.sv
`timescale 1ns/1ps
module lpdram_extreg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'b00;
    logic [12:0] addr = '0;
    logic [3:0]  bank_idle = 4'hF;
    logic [2:0]  refresh_area;
    logic [1:0]  drive_strength;
    logic        busy, err_timing, err_state, err_rsvd_bits, err_rsvd_code;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    lpdram_extreg u_lpdram_extreg (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .bank_idle(bank_idle),
        .refresh_area(refresh_area), .drive_strength(drive_strength), .busy(busy),
        .err_timing(err_timing), .err_state(err_state),
        .err_rsvd_bits(err_rsvd_bits), .err_rsvd_code(err_rsvd_code)
    );

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic check_regs(input int area, input int drv, input string tag);
        check(refresh_area, area, {tag, " area"});
        check(drive_strength, drv, {tag, " drive"});
    endtask

    function automatic logic [12:0] mk(input logic [2:0] area, input logic [1:0] drv);
        return {6'b0, drv, 2'b00, area};
    endfunction

    task automatic put(input logic cs, input logic ras, input logic cas, input logic we,
                       input logic [1:0] b, input logic [12:0] a, input logic k = 1'b1);
        @(negedge clk);
        cs_n = cs; ras_n = ras; cas_n = cas; we_n = we; ba = b; addr = a; cke = k;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic xwrite(input logic [12:0] a);
        put(1'b0, 1'b0, 1'b0, 1'b0, 2'b10, a);
        step();
    endtask

    task automatic nop();
        put(1'b1, 1'b1, 1'b1, 1'b1, 2'b00, '0);
        step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cke = 1'b1; bank_idle = 4'hF;
        step(); step();
        @(negedge clk);
        rst = 1'b0;
        nop();
    endtask

    task automatic t_reset();
        do_reset();
        check_regs(0, 1, "R1 default");
        check(busy, 0, "R1 busy");
        check({err_timing, err_state, err_rsvd_bits, err_rsvd_code}, 0, "R1 flags");
    endtask

    task automatic t_basic();
        do_reset();
        xwrite(mk(3'd1, 2'd0));
        check_regs(1, 0, "R2 first write");
        check(busy, 1, "R4 busy after write");
        nop();
        check(busy, 0, "R4 busy one cycle");
        check_regs(1, 0, "R2 held");
        xwrite(mk(3'd2, 2'd3));
        check_regs(2, 3, "R2 second write");
        nop();
        xwrite(mk(3'd0, 2'd2));
        check_regs(0, 2, "R2 third write");
        nop();
        check({err_timing, err_state, err_rsvd_bits, err_rsvd_code}, 0, "R2 no flags");
    endtask

    task automatic t_other_bank();
        for (int b = 0; b < 4; b++) begin
            if (b == 2) continue;
            put(1'b0, 1'b0, 1'b0, 1'b0, b[1:0], mk(3'd2, 2'd3));
            step();
            check_regs(0, 2, "R3 other bank unchanged");
            check({busy, err_timing, err_state, err_rsvd_bits, err_rsvd_code}, 0,
                  "R3 no busy or flags");
        end
        nop();
    endtask

    task automatic t_timing();
        do_reset();
        xwrite(mk(3'd1, 2'd3));
        xwrite(mk(3'd2, 2'd0));
        check_regs(1, 3, "R5 write in busy refused");
        check(err_timing, 1, "R5 timing flag on write");
        check(busy, 0, "R5 no new busy");
        do_reset();
        xwrite(mk(3'd1, 2'd0));
        put(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, '0);
        step();
        check(err_timing, 0, "R5 selected NOP harmless");
        nop();
        xwrite(mk(3'd2, 2'd2));
        put(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 13'h010);
        step();
        check(err_timing, 1, "R5 read in busy flagged");
        check_regs(2, 2, "R5 settings kept");
        nop();
    endtask

    task automatic t_cke();
        do_reset();
        put(1'b1, 1'b1, 1'b1, 1'b1, 2'b00, '0, 1'b0);
        step();
        put(1'b0, 1'b0, 1'b0, 1'b0, 2'b10, mk(3'd1, 2'd0), 1'b0);
        step();
        check(err_state, 1, "R6 cke low at command");
        check_regs(0, 1, "R6 unchanged low cke");
        do_reset();
        put(1'b1, 1'b1, 1'b1, 1'b1, 2'b00, '0, 1'b0);
        step();
        put(1'b0, 1'b0, 1'b0, 1'b0, 2'b10, mk(3'd1, 2'd0), 1'b1);
        step();
        check(err_state, 1, "R6 cke low one edge earlier");
        check_regs(0, 1, "R6 unchanged prior cke");
        check(busy, 0, "R6 no busy");
        nop();
    endtask

    task automatic t_idle();
        do_reset();
        @(negedge clk); bank_idle = 4'b1011;
        xwrite(mk(3'd2, 2'd3));
        check(err_state, 1, "R7 bank not idle");
        check_regs(0, 1, "R7 unchanged");
        @(negedge clk); bank_idle = 4'hF;
        nop();
        xwrite(mk(3'd2, 2'd3));
        check_regs(2, 3, "R7 accepted once idle");
        nop();
    endtask

    task automatic t_rsvd_bits();
        logic [12:0] extra [3] = '{13'h0080, 13'h0008, 13'h1000};
        for (int i = 0; i < 3; i++) begin
            do_reset();
            xwrite(mk(3'd1, 2'd1) | extra[i]);
            check(err_rsvd_bits, 1, "R8 reserved bit flagged");
            check_regs(0, 1, "R8 unchanged");
            check(busy, 0, "R8 no busy");
        end
        nop();
    endtask

    task automatic t_rsvd_code();
        do_reset();
        xwrite(mk(3'd5, 2'd2));
        check_regs(5, 2, "R9 reserved code stored");
        check(err_rsvd_code, 1, "R9 code flag");
        check(err_rsvd_bits, 0, "R9 no bit flag");
        nop();
        xwrite(mk(3'd0, 2'd0));
        check_regs(0, 0, "R10 rewrite after reserved code");
        nop(); nop();
        check(err_rsvd_code, 1, "R10 flag sticky");
    endtask

    task automatic t_rewrite();
        do_reset();
        xwrite(mk(3'd1, 2'd1));
        nop();
        put(1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 13'h0123);
        @(negedge clk); bank_idle = 4'b1101;
        step();
        for (int i = 0; i < 3; i++) begin
            put(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 13'(i * 8));
            step();
            put(1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 13'(i * 8 + 4));
            step();
        end
        put(1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 13'h0400);
        @(negedge clk); bank_idle = 4'hF;
        step();
        nop();
        xwrite(mk(3'd2, 2'd0));
        check_regs(2, 0, "R10 rewrite after traffic");
        check(err_timing | err_state, 0, "R10 traffic raised no flag");
        nop();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_other_bank();
        t_timing();
        t_cke();
        t_idle();
        t_rsvd_bits();
        t_rsvd_code();
        t_rewrite();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule